// File: doc/BRIEF.md
# ALU Operand Forwarding Select

This block picks where one ALU operand comes from in a five-stage in-order pipeline. The source register specifier of the instruction being read is compared with the destination specifiers of the two instructions ahead of it: the one holding an execute result (stage 3) and the one about to write back (stage 4). The output is a select code that steers the operand multiplexer to the register-file value, a stage-3 value or a stage-4 value. A second bit chooses between the two candidate values that each stage holds.

Stage 3 holds an ALU result and the incremented PC saved by a jump-and-link. Its return-address flag picks one of them. Stage 4 holds memory read data and an ALU result. Its write-data-source flag picks one of them. The younger stage 3 wins when both stages match. Register 0 is hard-wired to zero, so it never matches. The unit is purely combinational. One copy serves each ALU operand, and stall insertion for load-use cases belongs to a separate hazard detector.

Top module: `fwd_operand_sel`

## Requirements
- R1: When neither stage 3 nor stage 4 has its write enable set, `sel_stage_o` is 2 (register file) and `sel_alt_o` is 0.
- R2: When stage 4 writes to a destination that differs from `src_reg_i`, and stage 3 does not write to a matching destination, `sel_stage_o` is 2.
- R3: When stage 4 writes to a nonzero destination equal to `src_reg_i`, and stage 3 does not write to a matching destination, `sel_stage_o` is 4. `sel_alt_o` equals `s4_wb_src_i` (0 = memory read data, 1 = ALU result).
- R4: When stage 3 writes to a nonzero destination equal to `src_reg_i`, `sel_stage_o` is 3, whatever the stage-4 inputs are.
- R5: When `sel_stage_o` is 3, `sel_alt_o` equals `s3_ret_addr_i` (0 = ALU result, 1 = saved return address).
- R6: A destination of register 0 never counts as a match. With `src_reg_i` = 0 the output is always `sel_stage_o` = 2, `sel_alt_o` = 0.
- R7: The flag of a stage that is not selected has no effect. When `sel_stage_o` is 2, `sel_alt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_reg_i | input | REG_AW | Source register specifier of the operand |
| s3_wr_en_i | input | 1 | Stage-3 instruction writes a register |
| s3_dst_i | input | REG_AW | Stage-3 destination specifier |
| s3_ret_addr_i | input | 1 | Stage-3 result is the saved return address |
| s4_wr_en_i | input | 1 | Stage-4 instruction writes a register |
| s4_dst_i | input | REG_AW | Stage-4 destination specifier |
| s4_wb_src_i | input | 1 | Stage-4 write data source: 0 memory data, 1 ALU result |
| sel_stage_o | output | 3 | Operand source: 2 register file, 3 stage 3, 4 stage 4 |
| sel_alt_o | output | 1 | Chooses the second candidate value within the selected stage |

## Verification
The assertions assume that stage 3 never holds a load whose destination matches the source specifier. The hazard detector inserts a bubble in that case, so the stage-3 value is always a genuine result. The stimulus walks every combination of the two write enables, both match outcomes and both flags, and repeats them for several source specifiers including register 0. It drives only known values, so the checks never see X. Within this space the select code and the sub-select bit depend on nothing but the comparisons and flags listed in the requirements.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SRC_REGFILE = 3'd2,
    SRC_STAGE3  = 3'd3,
    SRC_STAGE4  = 3'd4
  } fwd_src_e;

  localparam int unsigned NUM_FWD_STAGES = 2;
  localparam int unsigned IDX_S3 = 0;
  localparam int unsigned IDX_S4 = 1;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int unsigned REG_AW   = 5,
  parameter int unsigned ZERO_REG = 0
) (
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] dst_i,
  input  logic [REG_AW-1:0] src_i,
  output logic              hit_o
);
  localparam logic [REG_AW-1:0] ZeroIdx = REG_AW'(ZERO_REG);

  logic same_reg;
  logic dst_live;

  always_comb begin
    same_reg = (dst_i == src_i);
    dst_live = (dst_i != ZeroIdx);
    hit_o    = wr_en_i & same_reg & dst_live;
  end
endmodule

// File: rtl/fwd_prio.sv
module fwd_prio
  import fwd_pkg::*;
(
  input  logic [NUM_FWD_STAGES-1:0] hit_i,
  input  logic [NUM_FWD_STAGES-1:0] alt_i,
  output fwd_src_e                  src_o,
  output logic                      alt_o
);
  // youngest stage (lowest index) wins
  always_comb begin
    src_o = SRC_REGFILE;
    alt_o = 1'b0;
    if (hit_i[IDX_S3]) begin
      src_o = SRC_STAGE3;
      alt_o = alt_i[IDX_S3];
    end else if (hit_i[IDX_S4]) begin
      src_o = SRC_STAGE4;
      alt_o = alt_i[IDX_S4];
    end
  end
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import fwd_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_reg_i,
  input  logic              s3_wr_en_i,
  input  logic [REG_AW-1:0] s3_dst_i,
  input  logic              s3_ret_addr_i,
  input  logic              s4_wr_en_i,
  input  logic [REG_AW-1:0] s4_dst_i,
  input  logic              s4_wb_src_i,
  output logic [SEL_W-1:0]  sel_stage_o,
  output logic              sel_alt_o
);
  logic [NUM_FWD_STAGES-1:0]             wr_en;
  logic [NUM_FWD_STAGES-1:0][REG_AW-1:0] dst;
  logic [NUM_FWD_STAGES-1:0]             alt;
  logic [NUM_FWD_STAGES-1:0]             hit;
  fwd_src_e                              src;

  always_comb begin
    wr_en[IDX_S3] = s3_wr_en_i;
    wr_en[IDX_S4] = s4_wr_en_i;
    dst[IDX_S3]   = s3_dst_i;
    dst[IDX_S4]   = s4_dst_i;
    alt[IDX_S3]   = s3_ret_addr_i;
    alt[IDX_S4]   = s4_wb_src_i;
  end

  for (genvar g = 0; g < NUM_FWD_STAGES; g++) begin : g_match
    fwd_match #(.REG_AW(REG_AW), .ZERO_REG(0)) u_match (
      .wr_en_i (wr_en[g]),
      .dst_i   (dst[g]),
      .src_i   (src_reg_i),
      .hit_o   (hit[g])
    );
  end

  fwd_prio u_prio (
    .hit_i (hit),
    .alt_i (alt),
    .src_o (src),
    .alt_o (sel_alt_o)
  );

  assign sel_stage_o = src;

  always_comb begin
    // R1
    no_writer_regfile_chk: assert (s3_wr_en_i || s4_wr_en_i || sel_stage_o == 3'd2);
    // R4
    s3_priority_chk: assert (!(s3_wr_en_i && s3_dst_i == src_reg_i && src_reg_i != '0)
                             || sel_stage_o == 3'd3);
    // R5
    s3_alt_chk: assert (sel_stage_o != 3'd3 || sel_alt_o == s3_ret_addr_i);
    // R3
    s4_alt_chk: assert (sel_stage_o != 3'd4 || sel_alt_o == s4_wb_src_i);
    // R6
    zero_reg_chk: assert (src_reg_i != '0 || sel_stage_o == 3'd2);
    // R7
    regfile_alt_chk: assert (sel_stage_o != 3'd2 || !sel_alt_o);
  end
endmodule

// File: tb/tb_fwd_operand_sel.sv
module tb_fwd_operand_sel;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] src_reg, s3_dst, s4_dst;
  logic s3_wr, s3_ret, s4_wr, s4_wb;
  logic [2:0] sel_stage;
  logic sel_alt;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  fwd_operand_sel #(.REG_AW(AW)) dut (
    .src_reg_i    (src_reg),
    .s3_wr_en_i   (s3_wr),
    .s3_dst_i     (s3_dst),
    .s3_ret_addr_i(s3_ret),
    .s4_wr_en_i   (s4_wr),
    .s4_dst_i     (s4_dst),
    .s4_wb_src_i  (s4_wb),
    .sel_stage_o  (sel_stage),
    .sel_alt_o    (sel_alt)
  );

  task automatic check(input string req, input int exp_stage, input int exp_alt);
    n_chk++;
    if (int'(sel_stage) != exp_stage || int'(sel_alt) != exp_alt) begin
      n_bad++;
      $display("FAIL %s: src=%0d s3(%0b,%0d,%0b) s4(%0b,%0d,%0b) got stage=%0d alt=%0d exp stage=%0d alt=%0d",
               req, src_reg, s3_wr, s3_dst, s3_ret, s4_wr, s4_dst, s4_wb,
               sel_stage, sel_alt, exp_stage, exp_alt);
    end
  endtask

  task automatic apply(input int src, input bit w3, input int d3, input bit r3,
                       input bit w4, input int d4, input bit b4);
    @(negedge clk);
    src_reg = AW'(src); s3_wr = w3; s3_dst = AW'(d3); s3_ret = r3;
    s4_wr = w4; s4_dst = AW'(d4); s4_wb = b4;
    @(posedge clk);
    #1;
  endtask

  // behavioural reference: returns stage code, alt, and requirement tag
  task automatic expect_for(input int src, input bit w3, input int d3, input bit r3,
                            input bit w4, input int d4, input bit b4,
                            output int st, output int al, output string req);
    bit m3, m4;
    m3 = w3 && d3 == src && src != 0;
    m4 = w4 && d4 == src && src != 0;
    if (m3) begin st = 3; al = r3; req = "R4/R5"; end
    else if (m4) begin st = 4; al = b4; req = "R3"; end
    else begin
      st = 2; al = 0;
      if (src == 0) req = "R6";
      else if (!w3 && !w4) req = "R1";
      else if (w4) req = "R2/R7";
      else req = "R7";
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end, got timeout exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int st, al;
    string req;
    int srcs[4] = '{0, 1, 7, 31};

    // reset-like idle state: nothing writes (R1)
    apply(5, 0, 5, 1, 0, 5, 1);
    check("R1", 2, 0);

    // directed corners
    apply(9, 0, 0, 0, 1, 8, 1);  check("R2", 2, 0);
    apply(9, 0, 0, 0, 1, 9, 0);  check("R3", 4, 0);
    apply(9, 0, 0, 0, 1, 9, 1);  check("R3", 4, 1);
    apply(9, 1, 9, 0, 1, 9, 1);  check("R4", 3, 0);
    apply(9, 1, 9, 1, 1, 9, 0);  check("R5", 3, 1);
    apply(0, 1, 0, 1, 1, 0, 1);  check("R6", 2, 0);
    apply(9, 1, 3, 1, 1, 9, 0);  check("R7", 4, 0);
    apply(9, 0, 9, 1, 0, 9, 1);  check("R7", 2, 0);

    // exhaustive truth-table walk
    foreach (srcs[k]) begin
      for (int v = 0; v < 64; v++) begin
        bit w3, w4, m3, m4, r3, b4;
        int d3, d4;
        {w3, w4, m3, m4, r3, b4} = 6'(v);
        d3 = m3 ? srcs[k] : (srcs[k] ^ 1);
        d4 = m4 ? srcs[k] : (srcs[k] ^ 2);
        apply(srcs[k], w3, d3, r3, w4, d4, b4);
        expect_for(srcs[k], w3, d3, r3, w4, d4, b4, st, al, req);
        check(req, st, al);
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule